// File: doc/BRIEF.md
# Double-Precision Maximum/Minimum Unit

This unit takes two IEEE-754 binary64 operands and returns either the larger or the smaller of them, as chosen by a select bit. NaN inputs, signed zeros and ordinary values are resolved under a fixed priority. Operand A is examined for NaN before operand B. A NaN that is chosen is passed through bit for bit and is never quieted. Two zeros are resolved by their signs alone. All other values are ordered numerically, and infinities and subnormals take their natural place in that order.

Alongside the result, the unit reports whether the NaN it chose was a signaling NaN. It also produces a destination write-enable, which is withheld when that report coincides with an enabled invalid-operation exception. The datapath is combinational and ends in one register stage. Each accepted request therefore appears on the outputs exactly one clock later, with the result, the flag and the write-enable aligned to each other.

Top module: `fp64_maxmin_unit`

## Requirements
- R1: When `op_a` is any NaN (bits 62:52 all ones and bits 51:0 nonzero), `res_data` equals `op_a` bit for bit, whatever `op_b` holds.
- R2: When `op_a` is not a NaN and `op_b` is any NaN, `res_data` equals `op_b` bit for bit.
- R3: `res_snan` is 1 only when the NaN chosen by R1/R2 is signaling, meaning fraction bit 51 is 0. A quiet NaN in `op_a` paired with a signaling NaN in `op_b` gives `op_a` with `res_snan` = 0.
- R4: With `pick_max` = 1 and both operands zero, the result is 64'h0 unless both zeros are negative, in which case it is 64'h8000_0000_0000_0000.
- R5: With `pick_max` = 0 and both operands zero, the result is 64'h8000_0000_0000_0000 if either zero is negative, and 64'h0 otherwise.
- R6: With `pick_max` = 1 and neither operand a NaN nor both zero, the result is `op_a` when A is not less than B, and `op_b` otherwise. Equal values give `op_a`.
- R7: With `pick_max` = 0 and neither operand a NaN nor both zero, the result is `op_a` when A is strictly less than B, and `op_b` otherwise.
- R8: `res_wr_en` is 0 when `res_snan` = 1 and the request's `inv_trap_en` was 1. Otherwise `res_wr_en` equals `res_valid`.
- R9: `res_valid` equals `req_valid` delayed by exactly one clock. The result, flag and write-enable belong to that request.
- R10: Synchronous active-high `rst` clears `res_valid`, `res_snan` and `res_wr_en` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| op_a | input | 64 | First operand (binary64) |
| op_b | input | 64 | Second operand (binary64) |
| pick_max | input | 1 | 1 = maximum, 0 = minimum |
| inv_trap_en | input | 1 | Invalid-operation exception enable |
| res_valid | output | 1 | Result is present |
| res_data | output | 64 | Selected value |
| res_snan | output | 1 | The chosen NaN was signaling |
| res_wr_en | output | 1 | Destination write-enable |

## Verification
The directed patterns cover four cases. The first is a NaN in A paired with a number, with a quiet NaN or with a signaling NaN in B; this separates strict A-first priority and selected-only signaling detection from any "either NaN is signaling" shortcut. The second is a NaN only in B. The third is all four sign pairings of two zeros under both selects, which exposes any confusion between maximum and minimum rules. The fourth is ordered pairs of mixed sign, both negative, equal values, infinities and subnormals, which tell a true sign-magnitude ordering apart from a raw unsigned comparison. A back-to-back stream of pseudo-random operands, with NaNs and zeros mixed in and the trap enable toggled, checks the one-cycle alignment and the write-enable suppression under sustained traffic.

// File: rtl/fp64_mm_pkg.sv
package fp64_mm_pkg;

    // Classification of one binary64 operand
    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_zero;
        logic sign;
    } fp_class_t;

    // Which value the selector forwards
    typedef enum logic [1:0] {
        SRC_A    = 2'd0,
        SRC_B    = 2'd1,
        SRC_POS0 = 2'd2,
        SRC_NEG0 = 2'd3
    } src_sel_t;

endpackage

// File: rtl/fp64_classify.sv
module fp64_classify
    import fp64_mm_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = EXP_W + FRAC_W + 1
) (
    input  logic [W-1:0] value,
    output fp_class_t    cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = value[W-2 -: EXP_W];
    assign frac_f = value[FRAC_W-1:0];

    always_comb begin
        cls.sign    = value[W-1];
        cls.is_nan  = (&exp_f) && (|frac_f);
        // Quiet bit is the top fraction bit; clear means signaling
        cls.is_snan = (&exp_f) && (|frac_f) && !frac_f[FRAC_W-1];
        cls.is_zero = ~|value[W-2:0];
    end
endmodule

// File: rtl/fp64_order_lt.sv
module fp64_order_lt #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_lt_b
);
    logic         sa;
    logic         sb;
    logic [W-2:0] ma;
    logic [W-2:0] mb;

    assign sa = a[W-1];
    assign sb = b[W-1];
    assign ma = a[W-2:0];
    assign mb = b[W-2:0];

    // Sign-magnitude ordering; valid for non-NaN inputs only
    always_comb begin
        unique case ({sa, sb})
            2'b00:   a_lt_b = (ma < mb);
            2'b11:   a_lt_b = (ma > mb);
            2'b10:   a_lt_b = (|ma) || (|mb);
            default: a_lt_b = 1'b0;
        endcase
    end
endmodule

// File: rtl/fp64_maxmin_sel.sv
module fp64_maxmin_sel
    import fp64_mm_pkg::*;
(
    input  fp_class_t cls_a,
    input  fp_class_t cls_b,
    input  logic      a_lt_b,
    input  logic      want_max,
    output src_sel_t  src,
    output logic      snan_hit
);
    always_comb begin
        snan_hit = 1'b0;
        if (cls_a.is_nan) begin
            src      = SRC_A;
            snan_hit = cls_a.is_snan;
        end else if (cls_b.is_nan) begin
            src      = SRC_B;
            snan_hit = cls_b.is_snan;
        end else if (cls_a.is_zero && cls_b.is_zero) begin
            if (want_max)
                src = (cls_a.sign && cls_b.sign) ? SRC_NEG0 : SRC_POS0;
            else
                src = (cls_a.sign || cls_b.sign) ? SRC_NEG0 : SRC_POS0;
        end else if (want_max) begin
            src = a_lt_b ? SRC_B : SRC_A;
        end else begin
            src = a_lt_b ? SRC_A : SRC_B;
        end
    end
endmodule

// File: rtl/fp64_maxmin_unit.sv
module fp64_maxmin_unit
    import fp64_mm_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = EXP_W + FRAC_W + 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         pick_max,
    input  logic         inv_trap_en,
    output logic         res_valid,
    output logic [W-1:0] res_data,
    output logic         res_snan,
    output logic         res_wr_en
);
    localparam int NOPS = 2;

    typedef struct packed {
        logic         valid;
        logic         snan;
        logic         wr_en;
        logic [W-1:0] data;
    } stage_t;

    logic [W-1:0] opnd [NOPS];
    fp_class_t    cls  [NOPS];
    logic         a_lt_b;
    src_sel_t     src;
    logic         snan_hit;
    stage_t       st_d;
    stage_t       st_q;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar i = 0; i < NOPS; i++) begin : g_cls
        fp64_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .value (opnd[i]),
            .cls   (cls[i])
        );
    end

    fp64_order_lt #(.W(W)) u_lt (
        .a      (op_a),
        .b      (op_b),
        .a_lt_b (a_lt_b)
    );

    fp64_maxmin_sel u_sel (
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .a_lt_b   (a_lt_b),
        .want_max (pick_max),
        .src      (src),
        .snan_hit (snan_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        st_d.snan  = 1'b0;
        st_d.wr_en = 1'b0;
        if (req_valid) begin
            unique case (src)
                SRC_A:    st_d.data = op_a;
                SRC_B:    st_d.data = op_b;
                SRC_POS0: st_d.data = '0;
                default:  st_d.data = {1'b1, {(W-1){1'b0}}};
            endcase
            st_d.snan  = snan_hit;
            st_d.wr_en = !(snan_hit && inv_trap_en);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign res_data  = st_q.data;
    assign res_snan  = st_q.snan;
    assign res_wr_en = st_q.wr_en;
endmodule

// File: rtl/fp64_maxmin_chk.sv
module fp64_maxmin_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         req_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         pick_max,
    input logic         inv_trap_en,
    input logic         res_valid,
    input logic [W-1:0] res_data,
    input logic         res_snan,
    input logic         res_wr_en
);
    localparam int FB = W - 13;   // quiet bit position (51 for binary64)

    function automatic logic nan_of(input logic [W-1:0] v);
        return (&v[W-2:W-12]) && (|v[W-13:0]);
    endfunction

    function automatic logic zero_of(input logic [W-1:0] v);
        return ~|v[W-2:0];
    endfunction

    logic plain_pos;
    assign plain_pos = !nan_of(op_a) && !nan_of(op_b) && !op_a[W-1] && !op_b[W-1];

    assert_nan_a_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid && nan_of(op_a) |=> res_data == $past(op_a));

    assert_nan_b_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid && !nan_of(op_a) && nan_of(op_b) |=> res_data == $past(op_b));

    assert_quiet_a_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid && nan_of(op_a) && op_a[FB] |=> !res_snan);

    assert_no_nan_flag_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid && !nan_of(op_a) && !nan_of(op_b) |=> !res_snan);

    assert_zero_max_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid && pick_max && zero_of(op_a) && zero_of(op_b)
        |=> res_data == {$past(op_a[W-1] && op_b[W-1]), {(W-1){1'b0}}});

    assert_zero_min_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid && !pick_max && zero_of(op_a) && zero_of(op_b)
        |=> res_data == {$past(op_a[W-1] || op_b[W-1]), {(W-1){1'b0}}});

    assert_pos_max_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid && pick_max && plain_pos && (op_a[W-2:0] > op_b[W-2:0])
        |=> res_data == $past(op_a));

    assert_pos_min_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid && !pick_max && plain_pos && (op_a[W-2:0] > op_b[W-2:0])
        |=> res_data == $past(op_b));

    assert_wr_untrapped_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid && !inv_trap_en |=> res_wr_en);

    assert_wr_trapped_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid && inv_trap_en && nan_of(op_a) && !op_a[FB] |=> !res_wr_en);

    assert_wr_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
        res_wr_en |-> res_valid);

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> !res_valid && !res_snan && !res_wr_en);
endmodule

bind fp64_maxmin_unit fp64_maxmin_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .op_a        (op_a),
    .op_b        (op_b),
    .pick_max    (pick_max),
    .inv_trap_en (inv_trap_en),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_snan    (res_snan),
    .res_wr_en   (res_wr_en)
);

// File: tb/tb_fp64_maxmin_unit.sv
module tb_fp64_maxmin_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        pick_max = 1'b0;
    logic        inv_trap_en = 1'b0;
    logic        res_valid;
    logic [63:0] res_data;
    logic        res_snan;
    logic        res_wr_en;

    always #2.5 clk = ~clk;   // 200 MHz

    fp64_maxmin_unit dut (
        .clk (clk), .rst (rst), .req_valid (req_valid),
        .op_a (op_a), .op_b (op_b), .pick_max (pick_max),
        .inv_trap_en (inv_trap_en), .res_valid (res_valid),
        .res_data (res_data), .res_snan (res_snan), .res_wr_en (res_wr_en)
    );

    typedef struct {
        logic [63:0] data;
        logic        snan;
        logic        wr_en;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          cyc = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    localparam logic [63:0] NEG0 = 64'h8000_0000_0000_0000;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic is_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
    endfunction

    // Expected values from the requirements; ordering via real arithmetic
    function automatic exp_t model(input logic [63:0] a, input logic [63:0] b,
                                   input logic mx, input logic ie);
        exp_t e;
        real  ra, rb;
        e.snan = 1'b0;
        if (is_nan(a)) begin
            e.data = a; e.snan = !a[51];
        end else if (is_nan(b)) begin
            e.data = b; e.snan = !b[51];
        end else if (a[62:0] == 63'd0 && b[62:0] == 63'd0) begin
            if (mx) e.data = (a[63] && b[63]) ? NEG0 : 64'd0;
            else    e.data = (a[63] || b[63]) ? NEG0 : 64'd0;
        end else begin
            ra = $bitstoreal(a);
            rb = $bitstoreal(b);
            if (mx) e.data = (ra >= rb) ? a : b;
            else    e.data = (ra <  rb) ? a : b;
        end
        e.wr_en = !(e.snan && ie);
        e.cyc   = 0;
        e.tag   = "";
        return e;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [63:0] a, input logic [63:0] b,
                         input logic mx, input logic ie, input string tag);
        exp_t e;
        @(negedge clk);
        op_a = a; op_b = b; pick_max = mx; inv_trap_en = ie; req_valid = 1'b1;
        e = model(a, b, mx, ie);
        e.cyc = cyc;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    // Monitor: compare each produced result with the queued expectation
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb_q.size() == 0) begin
                check("R9 unexpected res_valid", {63'd0, res_valid}, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({"R9 latency ", e.tag}, 64'(cyc - e.cyc), 64'd1);
                check({e.tag, " data"}, res_data, e.data);
                check({e.tag, " flag R3"}, {63'd0, res_snan}, {63'd0, e.snan});
                check({e.tag, " wr_en R8"}, {63'd0, res_wr_en}, {63'd0, e.wr_en});
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        n_bad++;
        $display("FAIL R9: watchdog expired, got no completion expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset valid", {63'd0, res_valid}, 64'd0);
        check("R10 reset flag",  {63'd0, res_snan},  64'd0);
        check("R10 reset wr_en", {63'd0, res_wr_en}, 64'd0);
        rst = 1'b0;

        // R1: NaN in A wins, no quieting
        drive(64'h7FF8_0000_0000_0001, 64'h3FF0_0000_0000_0000, 1'b1, 1'b0, "R1 qnan A");
        drive(64'h7FF0_0000_0000_0001, 64'h4000_0000_0000_0000, 1'b0, 1'b1, "R1 snan A trap");
        drive(64'h7FF0_0000_0000_0001, 64'h4000_0000_0000_0000, 1'b1, 1'b0, "R1 snan A notrap");
        // R3: quiet A with signaling B -> A, no flag
        drive(64'hFFF8_0000_0000_00AB, 64'h7FF0_0000_0000_0002, 1'b1, 1'b1, "R3 qA sB");
        drive(64'h7FF4_0000_0000_0000, 64'h7FF8_0000_0000_0000, 1'b0, 1'b1, "R3 sA qB");
        // R2: NaN in B only
        drive(64'h4000_0000_0000_0000, 64'h7FF8_0000_0000_0000, 1'b1, 1'b1, "R2 qnan B");
        drive(64'hBFF0_0000_0000_0000, 64'hFFF0_0000_0000_0001, 1'b0, 1'b1, "R2 snan B trap");
        drive(64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0001, 1'b0, 1'b0, "R2 inf vs snan");
        idle(1);
        // R4 / R5: signed zeros
        drive(64'd0, NEG0, 1'b1, 1'b0, "R4 max +0,-0");
        drive(NEG0, 64'd0, 1'b1, 1'b0, "R4 max -0,+0");
        drive(NEG0, NEG0,  1'b1, 1'b0, "R4 max -0,-0");
        drive(64'd0, 64'd0, 1'b1, 1'b0, "R4 max +0,+0");
        drive(64'd0, NEG0, 1'b0, 1'b0, "R5 min +0,-0");
        drive(NEG0, 64'd0, 1'b0, 1'b0, "R5 min -0,+0");
        drive(64'd0, 64'd0, 1'b0, 1'b0, "R5 min +0,+0");
        drive(NEG0, NEG0,  1'b0, 1'b0, "R5 min -0,-0");
        idle(2);
        // R6 / R7: ordering
        drive(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b1, 1'b0, "R6 1<2");
        drive(64'hC000_0000_0000_0000, 64'hC008_0000_0000_0000, 1'b1, 1'b0, "R6 -2,-3");
        drive(64'h4008_0000_0000_0000, 64'h4008_0000_0000_0000, 1'b1, 1'b0, "R6 equal");
        drive(64'hFFF0_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b1, 1'b0, "R6 -inf,subn");
        drive(64'h8000_0000_0000_0001, 64'd0, 1'b1, 1'b0, "R6 -subn,+0");
        drive(64'hBFF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0, 1'b0, "R7 -1,2");
        drive(64'hC000_0000_0000_0000, 64'hC008_0000_0000_0000, 1'b0, 1'b0, "R7 -2,-3");
        drive(64'h4008_0000_0000_0000, 64'h4008_0000_0000_0000, 1'b0, 1'b0, "R7 equal");
        drive(64'h7FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF, 1'b0, 1'b0, "R7 inf,max");
        drive(64'd0, 64'h8000_0000_0000_0003, 1'b0, 1'b0, "R7 +0,-subn");
        idle(1);
        // Stream: mixed traffic back to back
        for (int i = 0; i < 60; i++) begin
            logic [63:0] a, b;
            a = next_rand();
            b = next_rand();
            if (i % 7 == 3) a[62:52] = 11'h7FF;
            if (i % 5 == 1) b[62:52] = 11'h7FF;
            if (i % 9 == 4) begin a[62:0] = '0; b[62:0] = '0; end
            if (i % 4 == 2) a[62:52] = b[62:52];
            drive(a, b, rng[3], rng[9], "R6/R7 stream");
        end
        idle(4);
        check("R9 drained", 64'(sb_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule